// File: doc/BRIEF.md
# Timer Output Pin Controller

This block turns the per-channel compare-match pulses of a four-channel capture/compare timer into four output pin levels. Each channel owns an internal output flip-flop. In the default mode the flip-flop inverts on every match of its channel, so a periodic match produces a square wave on the pin.

Pins 0 and 2 each have a second mode in which two neighbouring channels act as a pair. A match on the lower channel of the pair sets the flip-flop, and a match on the upper channel clears it. This gives a pulse whose edges are placed by two compare values.

Each pin has an enable. A disabled pin drives a fixed level that software programs. The flip-flop behind a disabled pin keeps following its matches, so enabling the pin again shows the current flip-flop value at once. The control fields come in as plain inputs from the timer's register block.

Top module: `tmr_pin_ctl`

## Requirements
- R1: After reset every output flip-flop is 0, so an enabled pin reads 0 until its first match.
- R2: When a channel is in toggle mode, a match pulse (`match_i[n]` high at a rising clock edge) inverts flip-flop n, and pin n shows the new value after that edge.
- R3: While `pin_en_i[n]` is 0, `pin_o[n]` equals `fix_lvl_i[n]`, and the pin follows a change of either input within the same cycle.
- R4: The flip-flop updates on its matches while its pin is disabled. When `pin_en_i[n]` returns to 1, `pin_o[n]` shows the updated flip-flop value in the same cycle.
- R5: `pair_mode_i[0]` = 1 puts output 0 in set/reset mode: a match on channel 0 sets flip-flop 0 to 1 and a match on channel 1 clears it. `pair_mode_i[1]` = 1 does the same for output 2 with channels 2 (set) and 3 (clear).
- R6: In set/reset mode, when the set and clear matches arrive in the same cycle, the flip-flop becomes 0.
- R7: Outputs 1 and 3 always run in toggle mode. Neither pair mode bit changes how they respond to their own matches.
- R8: A flip-flop with no match that affects it in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_i | input | 4 | Single-cycle compare-match pulse per channel |
| pin_en_i | input | 4 | Per-pin output enable |
| fix_lvl_i | input | 4 | Level a disabled pin drives |
| pair_mode_i | input | 2 | Bit 0: set/reset mode for output 0; bit 1: set/reset mode for output 2 |
| pin_o | output | 4 | Timer output pin levels |

## Verification
A flip-flop that holds a wrong value reaches an enabled pin on the edge after the bad update. Because nothing reloads the flip-flop, the error stays visible until a later match happens to correct it. A wrong value in a flip-flop whose pin is disabled stays hidden behind the fixed level, so the bench re-enables pins after it drives matches into them while they are disabled. A swapped set/clear priority shows only when both pair matches arrive in the same cycle, so the bench drives that case on purpose.

// File: rtl/tmr_pin_ctl.sv
module tmr_pin_ctl #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] match_i,
  input  logic [NPIN-1:0] pin_en_i,
  input  logic [NPIN-1:0] fix_lvl_i,
  input  logic [NPIN/2-1:0] pair_mode_i,
  output logic [NPIN-1:0] pin_o
);

  localparam int NPAIR = NPIN / 2;

  logic [NPIN-1:0] ff_q;

  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      localparam int LO = 2 * p;
      localparam int HI = 2 * p + 1;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ff_q[LO] <= 1'b0;
        end else if (pair_mode_i[p]) begin
          if (match_i[HI])      ff_q[LO] <= 1'b0;
          else if (match_i[LO]) ff_q[LO] <= 1'b1;
        end else if (match_i[LO]) begin
          ff_q[LO] <= ~ff_q[LO];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ff_q[HI] <= 1'b0;
        else if (match_i[HI]) ff_q[HI] <= ~ff_q[HI];
      end

      // R2
      lo_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_mode_i[p] && match_i[LO]) |=> (ff_q[LO] != $past(ff_q[LO])));

      // R5
      lo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode_i[p] && match_i[LO] && !match_i[HI]) |=> ff_q[LO]);

      // R6
      lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode_i[p] && match_i[HI]) |=> !ff_q[LO]);

      // R7
      hi_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_i[HI] |=> (ff_q[HI] != $past(ff_q[HI])));

      // R8
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_i[LO] && !(pair_mode_i[p] && match_i[HI])) |=> $stable(ff_q[LO]));
    end
  endgenerate

  assign pin_o = (pin_en_i & ff_q) | (~pin_en_i & fix_lvl_i);

endmodule

// File: tb/tmr_pin_ctl_tb.sv
`timescale 1ns/1ps
module tmr_pin_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] match_i = '0, pin_en_i = '0, fix_lvl_i = '0;
  logic [1:0] pair_mode_i = '0;
  logic [3:0] pin_o;

  int   runs = 0, fails = 0;
  bit   done = 0;
  bit   mdl [4];

  always #10 clk = ~clk;

  tmr_pin_ctl u_dut (.clk, .rst_n, .match_i, .pin_en_i, .fix_lvl_i, .pair_mode_i, .pin_o);

  function automatic logic [3:0] expect_pins();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = pin_en_i[i] ? mdl[i] : fix_lvl_i[i];
    return e;
  endfunction

  task automatic check(string tag);
    logic [3:0] e = expect_pins();
    runs++;
    if (pin_o !== e) begin
      fails++;
      $display("FAIL %s: pin_o=%b expected %b", tag, pin_o, e);
    end
  endtask

  task automatic update_model();
    bit nx [4];
    for (int i = 0; i < 4; i++) begin
      nx[i] = mdl[i];
      if ((i % 2 == 0) && pair_mode_i[i/2]) begin
        if (match_i[i+1])  nx[i] = 0;
        else if (match_i[i]) nx[i] = 1;
      end else if (match_i[i]) nx[i] = !mdl[i];
    end
    for (int i = 0; i < 4; i++) mdl[i] = nx[i];
  endtask

  task automatic step(logic [3:0] m, logic [3:0] en, logic [3:0] fx, logic [1:0] sr, string tag);
    @(negedge clk);
    match_i = m; pin_en_i = en; fix_lvl_i = fx; pair_mode_i = sr;
    #1 check({tag, " R3 comb"});
    @(posedge clk);
    update_model();
    @(negedge clk);
    check(tag);
    match_i = '0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pin_en_i = 4'hF;
    #1 check("R1 reset");
    step(4'b0000, 4'hF, 4'h0, 2'b00, "R8 idle");
    step(4'b0001, 4'hF, 4'h0, 2'b00, "R2 toggle0");
    step(4'b1010, 4'hF, 4'h0, 2'b00, "R2 toggle13");
    step(4'b1111, 4'hF, 4'h0, 2'b00, "R2 toggle all");
    step(4'b0000, 4'h0, 4'b1010, 2'b00, "R3 fixed");
    step(4'b0000, 4'h0, 4'b0101, 2'b00, "R3 fixed2");
    step(4'b0101, 4'h0, 4'b0000, 2'b00, "R4 run disabled");
    step(4'b0000, 4'hF, 4'b0000, 2'b00, "R4 reenable");
    step(4'b0010, 4'hF, 4'h0, 2'b11, "R5 clear0");
    step(4'b0001, 4'hF, 4'h0, 2'b11, "R5 set0");
    step(4'b0001, 4'hF, 4'h0, 2'b11, "R5 set0 again");
    step(4'b0100, 4'hF, 4'h0, 2'b11, "R5 set2");
    step(4'b1000, 4'hF, 4'h0, 2'b11, "R5 clear2 R7");
    step(4'b0101, 4'hF, 4'h0, 2'b11, "R5 set both");
    step(4'b0011, 4'hF, 4'h0, 2'b11, "R6 pair0 both");
    step(4'b1100, 4'hF, 4'h0, 2'b11, "R6 pair2 both");
    step(4'b1010, 4'hF, 4'h0, 2'b00, "R7 odd toggle");
    step(4'b1010, 4'hF, 4'h0, 2'b11, "R7 odd toggle sr");
    step(4'b0000, 4'hF, 4'h0, 2'b11, "R8 hold sr");
    for (int k = 0; k < 400; k++)
      step(4'($urandom), 4'($urandom), 4'($urandom), 2'($urandom), "R2 R4 R5 R6 R7 random");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule